// File: doc/BRIEF.md
# Alternating Two-Buffer Framed Serial Word Transmitter

This block sends 32-bit words on one serial data line, one bit per clock and most significant bit first. A start strobe marks the first bit of every word and an end strobe marks the last bit. The words come from two local buffers, called threads. A byte-wide write port fills a buffer with a block of data, and a commit pulse hands the block over to the transmit engine.

The engine drains the two buffers in strict alternation. Words from the same buffer go out back to back. Every change from one buffer to the other costs exactly one dead clock. The engine never starts on a buffer that has no committed data.

For flow control each buffer reports a ready flag and a watermark flag. A one-cycle done pulse marks the final word of each block.

Top module: `pingpong_serial_tx`

## Requirements
- R1: Each word goes out most significant bit first, one bit per clock. A word is built from four written bytes in little-endian order: the first byte written lands in bits 7:0, and the fourth byte lands in bits 31:24. Consecutive words of one buffer start exactly 32 clocks apart.
- R2: `ser_sof` is high only during the first bit of a word, and `ser_eof` is high only during the 32nd bit of the same word.
- R3: When a buffer's last word ends and the other buffer is already ready, exactly one clock follows in which `ser_data`, `ser_sof` and `ser_eof` are all low. The start strobes around that switch are therefore 33 clocks apart.
- R4: Buffers are drained alternately, starting with buffer 0 after reset. The engine waits on the buffer whose turn it is, even if the other buffer is ready, and it never reads a buffer without committed data.
- R5: A committed block of N whole words (for example 128 bytes, N = 32) produces exactly N start strobes and N end strobes.
- R6: `buf_wm[t]` is high while buffer t is ready and the number of its words not yet started is at most `WM_LEVEL`. It is therefore high before the last word starts whenever `WM_LEVEL` is at least 1.
- R7: `buf_ready[t]` rises on the clock after a successful commit. It stays high through the final end strobe of the block and is low in the clock that follows.
- R8: `buf_done` pulses for one clock, together with the final end strobe of each block, and at no other time.
- R9: A buffer ignores writes and commits while it is ready. Writes beyond `DEPTH_WORDS` words are dropped. A commit with fewer than four pending bytes is ignored and keeps those bytes. Trailing bytes that do not fill a whole word are discarded at commit.
- R10: A synchronous active-high reset empties both buffers, selects buffer 0 and drives every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one byte into the selected buffer |
| wr_thread | input | 1 | Buffer selected for the write |
| wr_byte | input | 8 | Byte to append |
| commit | input | 1 | Hand the pending block of a buffer to the engine |
| commit_thread | input | 1 | Buffer selected for the commit |
| ser_data | output | 1 | Serial data bit |
| ser_sof | output | 1 | First-bit strobe |
| ser_eof | output | 1 | Last-bit strobe |
| buf_ready | output | 2 | Per-buffer committed-data flag |
| buf_wm | output | 2 | Per-buffer low-remaining watermark |
| buf_done | output | 1 | Final word of a block is ending |

## Verification
The assertions assume that a buffer is written or committed only while the engine is not draining it. They also assume that `wr_en` and `commit` are never raised in the same clock.

The bench keeps to these rules in every round. It loads buffer 1 first, then buffer 0, and waits until both blocks are fully drained before it starts the next round.

Block sizes are random within the depth. Directed rounds add single-word blocks, 128-byte blocks, overfilled blocks, partial trailing words, short commits and writes into a buffer that is ready.

// File: rtl/pst_pkg.sv
package pst_pkg;
   localparam int unsigned WORD_BITS = 32;
   localparam int unsigned BYTE_BITS = 8;
   localparam int unsigned LANES     = WORD_BITS / BYTE_BITS;
   localparam int unsigned THREADS   = 2;

   typedef enum logic {
      ENG_IDLE  = 1'b0,
      ENG_SHIFT = 1'b1
   } eng_state_t;

   typedef logic [WORD_BITS-1:0] word_t;
endpackage

// File: rtl/pst_buffer.sv
module pst_buffer
   import pst_pkg::*;
#(
   parameter int unsigned DEPTH_WORDS = 32,
   parameter int unsigned WM_LEVEL    = 1
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             wr_en,
   input  logic [BYTE_BITS-1:0]             wr_byte,
   input  logic                             commit,
   input  logic                             take,
   input  logic                             drain,
   output word_t                            rd_word,
   output logic                             ready,
   output logic                             wm,
   output logic [$clog2(DEPTH_WORDS):0]     words_left
);
   localparam int unsigned PTR_W    = $clog2(DEPTH_WORDS);
   localparam int unsigned CNT_W    = PTR_W + 1;
   localparam int unsigned LANE_W   = $clog2(LANES);
   localparam int unsigned FILL_W   = PTR_W + LANE_W + 1;
   localparam int unsigned FILL_MAX = DEPTH_WORDS * LANES;

   if (DEPTH_WORDS < 2 || (DEPTH_WORDS & (DEPTH_WORDS - 1)) != 0) begin : g_bad_depth
      $error("pst_buffer: DEPTH_WORDS must be a power of two of at least 2");
   end
   if (WM_LEVEL > DEPTH_WORDS) begin : g_bad_wm
      $error("pst_buffer: WM_LEVEL must not exceed DEPTH_WORDS");
   end

   word_t             mem [DEPTH_WORDS];
   logic [FILL_W-1:0] fill;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  rd_ptr;
   logic              wr_ok;
   logic              commit_ok;

   assign wr_ok     = wr_en && !ready && (fill < FILL_W'(FILL_MAX));
   assign commit_ok = commit && !ready && (fill >= FILL_W'(LANES));

   always_ff @(posedge clk) begin
      if (wr_ok) begin
         mem[fill[FILL_W-2:LANE_W]][int'(fill[LANE_W-1:0])*BYTE_BITS +: BYTE_BITS] <= wr_byte;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         fill   <= '0;
         cnt    <= '0;
         rd_ptr <= '0;
         ready  <= 1'b0;
      end else begin
         if (wr_ok) begin
            fill <= fill + FILL_W'(1);
         end
         if (commit_ok) begin
            cnt    <= fill[FILL_W-1:LANE_W];
            rd_ptr <= '0;
            ready  <= 1'b1;
            fill   <= '0;
         end
         if (take) begin
            rd_ptr <= rd_ptr + CNT_W'(1);
         end
         if (drain) begin
            ready <= 1'b0;
         end
      end
   end

   assign words_left = cnt - rd_ptr;
   assign wm         = ready && (words_left <= CNT_W'(WM_LEVEL));
   assign rd_word    = mem[rd_ptr[PTR_W-1:0]];

   // R7: a ready buffer stays ready until the engine drains it
   p_ready_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (ready && !drain) |=> ready);
   // R4: the engine only starts words that exist
   p_take_live_r4: assert property (@(posedge clk) disable iff (rst)
      take |-> (ready && words_left != '0));
   // R9: the fill pointer never passes the depth
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
      fill <= FILL_W'(FILL_MAX));
   // R6: the watermark is already up when the last word starts
   p_wm_before_last_r6: assert property (@(posedge clk) disable iff (rst)
      (take && words_left == CNT_W'(1) && WM_LEVEL >= 1) |-> wm);
endmodule

// File: rtl/pst_engine.sv
module pst_engine
   import pst_pkg::*;
(
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic [THREADS-1:0]                   ready_i,
   input  logic [THREADS-1:0]                   more_i,
   input  logic [THREADS-1:0][WORD_BITS-1:0]    words_i,
   output logic [THREADS-1:0]                   take_o,
   output logic [THREADS-1:0]                   drain_o,
   output logic                                 ser_data,
   output logic                                 ser_sof,
   output logic                                 ser_eof,
   output logic                                 done
);
   localparam int unsigned BIT_W = $clog2(WORD_BITS);

   eng_state_t       st;
   logic             sel;
   logic [BIT_W-1:0] bitcnt;
   word_t            shreg;
   logic             last_bit;
   logic             start;
   logic             finish;

   always_comb begin
      last_bit = (st == ENG_SHIFT) && (bitcnt == BIT_W'(WORD_BITS - 1));
      start    = ((st == ENG_IDLE) && ready_i[sel]) || (last_bit && more_i[sel]);
      finish   = last_bit && !more_i[sel];
      take_o   = '0;
      drain_o  = '0;
      take_o[sel]  = start;
      drain_o[sel] = finish;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= ENG_IDLE;
         sel    <= 1'b0;
         bitcnt <= '0;
         shreg  <= '0;
      end else if (start) begin
         st     <= ENG_SHIFT;
         shreg  <= words_i[sel];
         bitcnt <= '0;
      end else if (finish) begin
         st     <= ENG_IDLE;
         sel    <= ~sel;
      end else if (st == ENG_SHIFT) begin
         shreg  <= shreg << 1;
         bitcnt <= bitcnt + BIT_W'(1);
      end
   end

   assign ser_data = (st == ENG_SHIFT) && shreg[WORD_BITS-1];
   assign ser_sof  = (st == ENG_SHIFT) && (bitcnt == '0);
   assign ser_eof  = last_bit;
   assign done     = finish;

   // R2: the two strobes never coincide
   p_sof_eof_apart_r2: assert property (@(posedge clk) disable iff (rst)
      ser_sof |-> !ser_eof);
   // R3: one dead clock follows the end of a buffer
   p_gap_after_done_r3: assert property (@(posedge clk) disable iff (rst)
      done |=> !(ser_data || ser_sof || ser_eof));
   // R8: done only accompanies an end strobe
   p_done_on_eof_r8: assert property (@(posedge clk) disable iff (rst)
      done |-> ser_eof);
   // R4: finishing a buffer hands over to the other one
   p_alternate_r4: assert property (@(posedge clk) disable iff (rst)
      done |=> (sel != $past(sel)));
endmodule

// File: rtl/pingpong_serial_tx.sv
module pingpong_serial_tx
   import pst_pkg::*;
#(
   parameter int unsigned DEPTH_WORDS = 32,
   parameter int unsigned WM_LEVEL    = 1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       wr_en,
   input  logic       wr_thread,
   input  logic [7:0] wr_byte,
   input  logic       commit,
   input  logic       commit_thread,
   output logic       ser_data,
   output logic       ser_sof,
   output logic       ser_eof,
   output logic [1:0] buf_ready,
   output logic [1:0] buf_wm,
   output logic       buf_done
);
   localparam int unsigned CNT_W = $clog2(DEPTH_WORDS) + 1;

   logic [THREADS-1:0]                take;
   logic [THREADS-1:0]                drain;
   logic [THREADS-1:0]                more;
   logic [THREADS-1:0][WORD_BITS-1:0] words;

   for (genvar t = 0; t < THREADS; t++) begin : g_thread
      logic [CNT_W-1:0] left;
      word_t            rd;

      pst_buffer #(
         .DEPTH_WORDS(DEPTH_WORDS),
         .WM_LEVEL   (WM_LEVEL)
      ) i_buf (
         .clk       (clk),
         .rst       (rst),
         .wr_en     (wr_en && (wr_thread == 1'(t))),
         .wr_byte   (wr_byte),
         .commit    (commit && (commit_thread == 1'(t))),
         .take      (take[t]),
         .drain     (drain[t]),
         .rd_word   (rd),
         .ready     (buf_ready[t]),
         .wm        (buf_wm[t]),
         .words_left(left)
      );

      assign more[t]  = (left != '0);
      assign words[t] = rd;
   end

   pst_engine i_engine (
      .clk     (clk),
      .rst     (rst),
      .ready_i (buf_ready),
      .more_i  (more),
      .words_i (words),
      .take_o  (take),
      .drain_o (drain),
      .ser_data(ser_data),
      .ser_sof (ser_sof),
      .ser_eof (ser_eof),
      .done    (buf_done)
   );

   // R8: a block can only finish from a ready buffer
   p_done_from_ready_r8: assert property (@(posedge clk) disable iff (rst)
      buf_done |-> (buf_ready != 2'b00));
endmodule

// File: tb/test_pingpong_serial_tx.sv
`timescale 1ns/1ps
module test_pingpong_serial_tx;
   localparam int DEPTH = 32;
   localparam int WM    = 1;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0, wr_thread = 1'b0, commit = 1'b0, commit_thread = 1'b0;
   logic [7:0] wr_byte = 8'h00;
   logic       ser_data, ser_sof, ser_eof, buf_done;
   logic [1:0] buf_ready, buf_wm;

   always #2 clk = ~clk;

   pingpong_serial_tx #(.DEPTH_WORDS(DEPTH), .WM_LEVEL(WM)) i_pingpong_serial_tx (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_thread(wr_thread), .wr_byte(wr_byte),
      .commit(commit), .commit_thread(commit_thread), .ser_data(ser_data),
      .ser_sof(ser_sof), .ser_eof(ser_eof), .buf_ready(buf_ready), .buf_wm(buf_wm),
      .buf_done(buf_done));

   int n_checks = 0;
   int n_fail   = 0;

   function automatic void chk(bit ok, string req, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endfunction

   // reference model state
   logic [7:0]  pend0[$], pend1[$];
   logic [31:0] qw0[$], qw1[$];
   int          qn0[$], qn1[$];
   bit          qs0[$], qs1[$];
   bit          mready [2];
   int          sof_total = 0, eof_total = 0, exp_words = 0;

   function automatic int pend_size(int t);
      return (t != 0) ? pend1.size() : pend0.size();
   endfunction

   task automatic put_byte(int t, logic [7:0] b);
      @(negedge clk);
      wr_en = 1'b1; wr_thread = t[0]; wr_byte = b;
      if (!mready[t] && pend_size(t) < DEPTH*4) begin
         if (t != 0) pend1.push_back(b); else pend0.push_back(b);
      end
   endtask

   task automatic fill_rand(int t, int nbytes);
      for (int i = 0; i < nbytes; i++) put_byte(t, 8'($urandom));
   endtask

   task automatic do_commit(int t, bit seamless);
      int nw;
      logic [31:0] w;
      @(negedge clk);
      wr_en = 1'b0; commit = 1'b1; commit_thread = t[0];
      if (!mready[t] && pend_size(t) >= 4) begin
         nw = pend_size(t) / 4;
         for (int i = 0; i < nw; i++) begin
            if (t != 0) begin
               w = {pend1[4*i+3], pend1[4*i+2], pend1[4*i+1], pend1[4*i]};
               qw1.push_back(w);
            end else begin
               w = {pend0[4*i+3], pend0[4*i+2], pend0[4*i+1], pend0[4*i]};
               qw0.push_back(w);
            end
         end
         if (t != 0) begin qn1.push_back(nw); qs1.push_back(seamless); pend1.delete(); end
         else        begin qn0.push_back(nw); qs0.push_back(seamless); pend0.delete(); end
         mready[t] = 1'b1;
         exp_words += nw;
      end
      @(negedge clk);
      commit = 1'b0;
   endtask

   task automatic wait_drain;
      while (mready[0] || mready[1]) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   // output monitor
   bit          mon_thr = 1'b0, in_word = 1'b0, prev_done = 1'b0;
   int          prev_thr = 0, bitpos = 0, widx = 0, cur_n = 0;
   logic [31:0] cap, expw;
   longint      cyc = 0, last_sof = -1;

   always @(negedge clk) begin
      cyc++;
      if (rst) begin
         in_word = 1'b0;
      end else begin
         if (prev_done) begin
            chk({ser_data, ser_sof, ser_eof} == 3'b000, "R3 dead clock after buffer end",
                {ser_data, ser_sof, ser_eof}, 0);
            chk(buf_ready[prev_thr] == 1'b0, "R7 ready low after final EOF",
                buf_ready[prev_thr], 0);
         end
         prev_done = 1'b0;
         if (!in_word && ser_eof) chk(1'b0, "R2 EOF outside a word", 1, 0);
         if (ser_sof) begin
            sof_total++;
            chk(!in_word, "R2 SOF inside a word", in_word, 0);
            if (((mon_thr != 0) ? qw1.size() : qw0.size()) == 0) begin
               chk(1'b0, "R4 output from buffer without committed data", mon_thr, 0);
               in_word = 1'b0;
            end else begin
               if (widx == 0) begin
                  cur_n = (mon_thr != 0) ? qn1[0] : qn0[0];
                  if (((mon_thr != 0) ? qs1[0] : qs0[0]) && last_sof >= 0)
                     chk(cyc - last_sof == 33, "R3 33-clock SOF gap at switch", cyc - last_sof, 33);
               end else begin
                  chk(cyc - last_sof == 32, "R1 back-to-back word spacing", cyc - last_sof, 32);
               end
               chk(buf_ready[mon_thr] == 1'b1, "R7 ready while draining", buf_ready[mon_thr], 1);
               chk(buf_wm[mon_thr] == ((cur_n - widx - 1) <= WM), "R6 watermark at word start",
                   buf_wm[mon_thr], ((cur_n - widx - 1) <= WM));
               in_word = 1'b1; bitpos = 0; cap = '0;
            end
            last_sof = cyc;
         end
         if (in_word) begin
            cap = {cap[30:0], ser_data};
            if (ser_eof) begin
               eof_total++;
               chk(bitpos == 31, "R2 EOF on last bit", bitpos, 31);
               expw = (mon_thr != 0) ? qw1.pop_front() : qw0.pop_front();
               chk(cap == expw, "R1 word MSB first from LE bytes", cap, expw);
               widx++;
               chk(buf_done == (widx == cur_n), "R8 done with final EOF only", buf_done, (widx == cur_n));
               if (widx == cur_n) begin
                  if (mon_thr != 0) begin void'(qn1.pop_front()); void'(qs1.pop_front()); end
                  else              begin void'(qn0.pop_front()); void'(qs0.pop_front()); end
                  mready[mon_thr] = 1'b0;
                  prev_done = 1'b1; prev_thr = mon_thr;
                  mon_thr = ~mon_thr; widx = 0;
               end
               in_word = 1'b0;
            end else begin
               if (bitpos >= 31) begin
                  chk(1'b0, "R2 EOF missing on bit 32", bitpos, 31);
                  in_word = 1'b0;
               end
               bitpos++;
            end
         end
      end
   end

   // watchdog
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual %0d expected <150000 cycles", wd);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   task automatic run_round(int nb1, int nb0);
      int s0, e0, w0;
      s0 = sof_total; e0 = eof_total; w0 = exp_words;
      fill_rand(1, nb1);
      do_commit(1, 1'b1);
      repeat (10) @(negedge clk);
      chk(sof_total == s0, "R4 engine waits for its turn", sof_total - s0, 0);
      chk(buf_ready == 2'b10, "R4 only buffer 1 ready", buf_ready, 2'b10);
      fill_rand(0, nb0);
      do_commit(0, 1'b0);
      wait_drain();
      chk(sof_total - s0 == exp_words - w0, "R5 SOF count per round", sof_total - s0, exp_words - w0);
      chk(eof_total - e0 == exp_words - w0, "R5 EOF count per round", eof_total - e0, exp_words - w0);
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk({ser_data, ser_sof, ser_eof, buf_done, buf_ready, buf_wm} == 0, "R10 outputs low in reset",
          {ser_data, ser_sof, ser_eof, buf_done, buf_ready, buf_wm}, 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      chk(buf_ready == 2'b00, "R10 buffers empty after reset", buf_ready, 0);

      // R9: short commit ignored, bytes kept
      fill_rand(1, 2);
      do_commit(1, 1'b1);
      repeat (3) @(negedge clk);
      chk(buf_ready == 2'b00, "R9 short commit ignored", buf_ready, 0);
      // R5 directed: two 128-byte blocks (2 pending + 126)
      begin
         int s0;
         s0 = sof_total;
         fill_rand(1, 126);
         do_commit(1, 1'b1);
         repeat (10) @(negedge clk);
         chk(buf_ready == 2'b10 && sof_total == s0, "R4 waits on buffer 0", buf_ready, 2'b10);
         // R9: writes and commit while ready are ignored
         fill_rand(1, 8);
         do_commit(1, 1'b1);
         fill_rand(0, 128);
         do_commit(0, 1'b0);
         wait_drain();
         chk(sof_total - s0 == 64, "R5 two 128-byte blocks give 64 SOF", sof_total - s0, 64);
      end
      // single-word blocks
      run_round(4, 4);
      // R9 overflow on buffer 1, partial trailing word on buffer 0
      run_round(DEPTH*4 + 8, 4*5 + 3);
      // random rounds
      for (int r = 0; r < 8; r++) begin
         run_round(4*$urandom_range(1, DEPTH) + $urandom_range(0, 3),
                   4*$urandom_range(1, DEPTH) + $urandom_range(0, 3));
      end
      chk(qw0.size() == 0 && qw1.size() == 0, "R5 all committed words sent",
          qw0.size() + qw1.size(), 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule